// File: doc/BRIEF.md
# Character Display Command Engine

This block is the instruction processor of a character display controller. A host interface hands it one byte per command, tagged with a register-select bit (`cmd_rs`) and a read/write bit (`cmd_rw`). The engine decodes the byte and runs it against two internal memories. The first is a 128-entry character-code RAM. The second is a 64-entry user-glyph RAM. The engine keeps the address counter, the entry-mode flags, the display-control flags, the function flags and a horizontal shift offset for the visible window.

Reads return either RAM data or the address counter on `rd_data`, one cycle after the command is accepted. Every control flag and the shift offset are driven out as plain outputs, so that a separate renderer can build the picture. A blink timebase gives a square wave whose half-period is a parameter.

After reset, and after a clear command, a sequencer writes the space code into the character RAM, one location per cycle. A command that arrives while this fill runs is parked in a one-entry holding register. It runs in the first cycle after the fill ends.

Top module: `chardisp_cmd_engine`

## Requirements
- R1: After reset the block shows this state: inc_mode=1, shift_mode=0, disp_on/cursor_on/blink_on=0, bus_8bit=1, two_line=TWO_LINE_INIT (default 1), bright=00, ac_out=00h, character access selected, shift_offset=0. Once the fill is done, every character location reads 20h.
- R2: A byte with RS=0 and RW=0 is decoded by its highest set bit:
  - bit7: character address = byte[6:0].
  - bit6: glyph address = byte[5:0].
  - bit5: function set, with bus_8bit=b4, two_line=b3, bright=b1:0.
  - bit4: cursor/display shift.
  - bit3: display control, with disp_on=b2, cursor_on=b1, blink_on=b0.
  - bit2: entry mode, with inc_mode=b1, shift_mode=b0.
  - bit1: home.
  - bit0: clear.
  - The byte 00h changes nothing.
- R3: In two-line mode the character address steps as follows. Incrementing, 27h goes to 40h and 67h goes to 00h. Decrementing, 40h goes to 27h and 00h goes to 67h. Any other value moves by one.
- R4: In one-line mode the character address wraps 4Fh↔00h. The glyph address wraps 3Fh↔00h in both modes. While a glyph address is selected, ac_out[6] is 0.
- R5: RS=1, RW=0 writes the byte into the RAM named by the most recent address-set command. RS=1, RW=1 reads that RAM. Either access then moves ac_out by one in the direction given by inc_mode. Read data appears with rd_valid=1 in the cycle after the command.
- R6: With shift_mode=1, every character write moves shift_offset. It moves left (+1) when inc_mode=1 and right (−1) when inc_mode=0, modulo 40 in two-line mode and modulo 80 in one-line mode. Reads and glyph writes leave shift_offset alone.
- R7: The shift command moves the address counter up when byte[2]=1 and down when byte[2]=0, using character wrapping. Afterwards character access is selected. With byte[3]=1 the window also moves: right when byte[2]=1, left when byte[2]=0.
- R8: RS=0, RW=1 returns {0, ac_out} on rd_data. Bit 7 is the busy flag and always reads 0.
- R9: Clear sets ac_out=0, selects character access, sets shift_offset=0 and sets inc_mode=1. It then refills all 128 character locations with 20h at one location per cycle. Glyph RAM contents survive.
- R10: Home sets ac_out=0, selects character access and sets shift_offset=0. Neither RAM changes.
- R11: A command accepted while the fill runs waits in a one-entry holder. It executes after the last fill write, and the fill does not overwrite it.
- R12: While blink_on=1, blink_phase toggles every BLINK_HALF cycles, so that a suitable BLINK_HALF gives about 1 Hz at 50% duty. While blink_on=0, blink_phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_rs | input | 1 | 0 = instruction, 1 = RAM data |
| cmd_rw | input | 1 | 0 = write, 1 = read |
| cmd_byte | input | 8 | Instruction or data byte |
| rd_valid | output | 1 | rd_data holds read result |
| rd_data | output | 8 | RAM data, or busy flag and address counter |
| ac_out | output | 7 | Address counter (cursor position) |
| ac_is_glyph | output | 1 | Address counter points into glyph RAM |
| shift_offset | output | 7 | Display window shift offset |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| blink_phase | output | 1 | Blink timebase |
| inc_mode | output | 1 | Address counter steps up (1) or down (0) |
| shift_mode | output | 1 | Shift window on character writes |
| bus_8bit | output | 1 | Host bus width flag (1 = 8-bit) |
| two_line | output | 1 | Two-line mode |
| bright | output | 2 | Brightness code |

## Verification
The assertions assume two things about the host. First, it never strobes a second command while one is already parked during a fill. Second, `cmd_valid` is a single-cycle pulse. The bench drives every command as a one-cycle pulse with at least one idle cycle after it. While a fill is running it issues at most one command, and otherwise it waits out the full 128-cycle fill before sending more. The shift-offset range check also assumes that the line mode is not changed while the window is shifted. The bench returns to home before any line-mode change.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

  parameter int CHAR_AW  = 7;
  parameter int GLYPH_AW = 6;
  parameter int DATA_W   = 8;
  parameter int LEN_ONE  = 80;
  parameter int LEN_TWO  = 40;

  typedef enum logic [3:0] {
    OP_NOP, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP, OP_SHIFT,
    OP_FUNC, OP_GADDR, OP_CADDR, OP_ACRD, OP_DWR, OP_DRD
  } op_e;

  // Instruction decode: highest set bit wins when rs = 0.
  function automatic op_e decode_op(input logic rs, input logic rw,
                                    input logic [DATA_W-1:0] b);
    op_e o;
    if (rs) o = rw ? OP_DRD : OP_DWR;
    else if (rw) o = OP_ACRD;
    else if (b[7]) o = OP_CADDR;
    else if (b[6]) o = OP_GADDR;
    else if (b[5]) o = OP_FUNC;
    else if (b[4]) o = OP_SHIFT;
    else if (b[3]) o = OP_DISP;
    else if (b[2]) o = OP_ENTRY;
    else if (b[1]) o = OP_HOME;
    else if (b[0]) o = OP_CLEAR;
    else o = OP_NOP;
    return o;
  endfunction

  // Character address step, with the split two-line layout.
  function automatic logic [CHAR_AW-1:0] char_step(input logic [CHAR_AW-1:0] a,
                                                   input logic up, input logic two);
    logic [CHAR_AW-1:0] n;
    if (two) begin
      if (up) n = (a == 7'h27) ? 7'h40 : (a == 7'h67) ? 7'h00 : a + 7'd1;
      else    n = (a == 7'h40) ? 7'h27 : (a == 7'h00) ? 7'h67 : a - 7'd1;
    end else begin
      if (up) n = (a == 7'(LEN_ONE-1)) ? 7'h00 : a + 7'd1;
      else    n = (a == 7'h00) ? 7'(LEN_ONE-1) : a - 7'd1;
    end
    return n;
  endfunction

  // Glyph address step: plain modulo of the glyph RAM size.
  function automatic logic [GLYPH_AW-1:0] glyph_step(input logic [GLYPH_AW-1:0] a,
                                                     input logic up);
    return up ? a + 1'b1 : a - 1'b1;
  endfunction

  // Window offset step: left means +1, right means -1, modulo line length.
  function automatic logic [CHAR_AW-1:0] offset_step(input logic [CHAR_AW-1:0] off,
                                                     input logic left, input logic two);
    logic [CHAR_AW-1:0] last;
    last = two ? 7'(LEN_TWO-1) : 7'(LEN_ONE-1);
    if (left) return (off >= last) ? 7'd0 : off + 7'd1;
    else      return (off == 7'd0) ? last : off - 7'd1;
  endfunction

endpackage

// File: rtl/chardisp_ram.sv
module chardisp_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/chardisp_fill.sv
module chardisp_fill #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          active,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b1;
      addr   <= '0;
    end else if (start) begin
      active <= 1'b1;
      addr   <= '0;
    end else if (active) begin
      addr <= addr + 1'b1;
      if (addr == LAST) active <= 1'b0;
    end
  end

  // R9
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $past(rst_n) && !$past(start)) |-> (addr == $past(addr) + 1'b1));
endmodule

// File: rtl/chardisp_blink.sv
module chardisp_blink #(
  parameter int HALF = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic phase
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R12
  blink_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !phase);
endmodule

// File: rtl/chardisp_cmd_engine.sv
module chardisp_cmd_engine
  import chardisp_pkg::*;
#(
  parameter int   BLINK_HALF    = 50_000_000,
  parameter logic TWO_LINE_INIT = 1'b1,
  parameter logic [7:0] FILL_CODE = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       cmd_rs,
  input  logic       cmd_rw,
  input  logic [7:0] cmd_byte,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic [6:0] ac_out,
  output logic       ac_is_glyph,
  output logic [6:0] shift_offset,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       blink_phase,
  output logic       inc_mode,
  output logic       shift_mode,
  output logic       bus_8bit,
  output logic       two_line,
  output logic [1:0] bright
);
  typedef enum logic [1:0] {SRC_AC, SRC_CHAR, SRC_GLYPH} rd_src_e;

  // Holding register for a command that arrives during a fill
  logic              pend_v, pend_rs, pend_rw;
  logic [DATA_W-1:0] pend_byte;

  logic              fill_active;
  logic [CHAR_AW-1:0] fill_addr;

  // Named internal events
  logic              exec_fire;
  logic              exec_rs, exec_rw;
  logic [DATA_W-1:0] exec_byte;
  op_e               exec_op;
  logic              fill_start;
  logic              char_we, glyph_we, char_re, glyph_re;

  logic [DATA_W-1:0] char_q, glyph_q, ac_q;
  rd_src_e           rd_src;

  assign exec_fire  = !fill_active && (pend_v || cmd_valid);
  assign exec_rs    = pend_v ? pend_rs   : cmd_rs;
  assign exec_rw    = pend_v ? pend_rw   : cmd_rw;
  assign exec_byte  = pend_v ? pend_byte : cmd_byte;
  assign exec_op    = exec_fire ? decode_op(exec_rs, exec_rw, exec_byte) : OP_NOP;
  assign fill_start = (exec_op == OP_CLEAR);

  assign char_we  = fill_active || (exec_op == OP_DWR && !ac_is_glyph);
  assign glyph_we = (exec_op == OP_DWR) && ac_is_glyph;
  assign char_re  = (exec_op == OP_DRD) && !ac_is_glyph;
  assign glyph_re = (exec_op == OP_DRD) && ac_is_glyph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_rs   <= 1'b0;
      pend_rw   <= 1'b0;
      pend_byte <= '0;
    end else if (fill_active) begin
      if (cmd_valid) begin
        pend_v    <= 1'b1;
        pend_rs   <= cmd_rs;
        pend_rw   <= cmd_rw;
        pend_byte <= cmd_byte;
      end
    end else if (pend_v) begin
      pend_v <= cmd_valid;
      if (cmd_valid) begin
        pend_rs   <= cmd_rs;
        pend_rw   <= cmd_rw;
        pend_byte <= cmd_byte;
      end
    end
  end

  // Architectural state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_out       <= '0;
      ac_is_glyph  <= 1'b0;
      shift_offset <= '0;
      inc_mode     <= 1'b1;
      shift_mode   <= 1'b0;
      disp_on      <= 1'b0;
      cursor_on    <= 1'b0;
      blink_on     <= 1'b0;
      bus_8bit     <= 1'b1;
      two_line     <= TWO_LINE_INIT;
      bright       <= 2'b00;
    end else begin
      unique case (exec_op)
        OP_CLEAR: begin
          ac_out       <= '0;
          ac_is_glyph  <= 1'b0;
          shift_offset <= '0;
          inc_mode     <= 1'b1;
        end
        OP_HOME: begin
          ac_out       <= '0;
          ac_is_glyph  <= 1'b0;
          shift_offset <= '0;
        end
        OP_ENTRY: begin
          inc_mode   <= exec_byte[1];
          shift_mode <= exec_byte[0];
        end
        OP_DISP: begin
          disp_on   <= exec_byte[2];
          cursor_on <= exec_byte[1];
          blink_on  <= exec_byte[0];
        end
        OP_SHIFT: begin
          ac_out      <= char_step(ac_out, exec_byte[2], two_line);
          ac_is_glyph <= 1'b0;
          if (exec_byte[3])
            shift_offset <= offset_step(shift_offset, !exec_byte[2], two_line);
        end
        OP_FUNC: begin
          bus_8bit <= exec_byte[4];
          two_line <= exec_byte[3];
          bright   <= exec_byte[1:0];
        end
        OP_GADDR: begin
          ac_out      <= {1'b0, exec_byte[GLYPH_AW-1:0]};
          ac_is_glyph <= 1'b1;
        end
        OP_CADDR: begin
          ac_out      <= exec_byte[CHAR_AW-1:0];
          ac_is_glyph <= 1'b0;
        end
        OP_DWR, OP_DRD: begin
          if (ac_is_glyph)
            ac_out <= {1'b0, glyph_step(ac_out[GLYPH_AW-1:0], inc_mode)};
          else
            ac_out <= char_step(ac_out, inc_mode, two_line);
          if (exec_op == OP_DWR && !ac_is_glyph && shift_mode)
            shift_offset <= offset_step(shift_offset, inc_mode, two_line);
        end
        default: ;
      endcase
    end
  end

  // Read return path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_src   <= SRC_AC;
      ac_q     <= '0;
    end else begin
      rd_valid <= (exec_op == OP_ACRD) || (exec_op == OP_DRD);
      if (exec_op == OP_ACRD) begin
        rd_src <= SRC_AC;
        ac_q   <= {1'b0, ac_out};
      end else if (exec_op == OP_DRD) begin
        rd_src <= ac_is_glyph ? SRC_GLYPH : SRC_CHAR;
      end
    end
  end

  always_comb begin
    unique case (rd_src)
      SRC_CHAR:  rd_data = char_q;
      SRC_GLYPH: rd_data = glyph_q;
      default:   rd_data = ac_q;
    endcase
  end

  chardisp_ram #(.AW(CHAR_AW), .DW(DATA_W)) u_char_ram (
    .clk   (clk),
    .we    (char_we),
    .waddr (fill_active ? fill_addr : ac_out),
    .wdata (fill_active ? FILL_CODE : exec_byte),
    .re    (char_re),
    .raddr (ac_out),
    .rdata (char_q)
  );

  chardisp_ram #(.AW(GLYPH_AW), .DW(DATA_W)) u_glyph_ram (
    .clk   (clk),
    .we    (glyph_we),
    .waddr (ac_out[GLYPH_AW-1:0]),
    .wdata (exec_byte),
    .re    (glyph_re),
    .raddr (ac_out[GLYPH_AW-1:0]),
    .rdata (glyph_q)
  );

  chardisp_fill #(.AW(CHAR_AW)) u_fill (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (fill_start),
    .active (fill_active),
    .addr   (fill_addr)
  );

  chardisp_blink #(.HALF(BLINK_HALF)) u_blink (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (blink_on),
    .phase (blink_phase)
  );

  // R5
  rd_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(exec_fire));
  // R11
  park_during_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_active && cmd_valid) |=> pend_v);
  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_v && fill_active && cmd_valid));
  // R4
  glyph_ac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ac_is_glyph |-> (ac_out[6] == 1'b0));
  // R6
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_offset < 7'(LEN_ONE));
  // R9
  clear_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |=> fill_active);
endmodule

// File: tb/chardisp_cmd_engine_test.sv
`timescale 1ns/1ps
module chardisp_cmd_engine_test;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_rs = 1'b0, cmd_rw = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic rd_valid, ac_is_glyph, disp_on, cursor_on, blink_on, blink_phase;
  logic inc_mode, shift_mode, bus_8bit, two_line;
  logic [7:0] rd_data;
  logic [6:0] ac_out, shift_offset;
  logic [1:0] bright;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chardisp_cmd_engine #(.BLINK_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rs(cmd_rs),
    .cmd_rw(cmd_rw), .cmd_byte(cmd_byte), .rd_valid(rd_valid), .rd_data(rd_data),
    .ac_out(ac_out), .ac_is_glyph(ac_is_glyph), .shift_offset(shift_offset),
    .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on),
    .blink_phase(blink_phase), .inc_mode(inc_mode), .shift_mode(shift_mode),
    .bus_8bit(bus_8bit), .two_line(two_line), .bright(bright)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic rs, input logic rw, input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rs = rs; cmd_rw = rw; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ins(input logic [7:0] b); send(1'b0, 1'b0, b); endtask
  task automatic wrd(input logic [7:0] b); send(1'b1, 1'b0, b); endtask

  task automatic rdd(input string req, input logic [7:0] exp);
    send(1'b1, 1'b1, 8'h00);
    chk({req, " rd_valid"}, {7'd0, rd_valid}, 8'h01);
    chk(req, rd_data, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 inc", {7'd0, inc_mode}, 8'h01);
    chk("R1 shift", {7'd0, shift_mode}, 8'h00);
    chk("R1 dcb", {5'd0, disp_on, cursor_on, blink_on}, 8'h00);
    chk("R1 func", {4'd0, bus_8bit, two_line, bright}, 8'h0C);
    chk("R1 ac", {1'b0, ac_out}, 8'h00);
    chk("R1 off", {1'b0, shift_offset}, 8'h00);
    idle(140);
    rdd("R1 ram[00]", 8'h20);
    ins(8'hFF);
    rdd("R1 ram[7F]", 8'h20);
  endtask

  task automatic t_decode;
    ins(8'h00);
    chk("R2 nop", {inc_mode, shift_mode, disp_on, cursor_on, blink_on, bus_8bit, two_line, 1'b0}, 8'h86);
    ins(8'h04);
    chk("R2 entry", {6'd0, inc_mode, shift_mode}, 8'h00);
    ins(8'h07);
    chk("R2 entry", {6'd0, inc_mode, shift_mode}, 8'h03);
    ins(8'h0F);
    chk("R2 disp", {5'd0, disp_on, cursor_on, blink_on}, 8'h07);
    ins(8'h0A);
    chk("R2 disp", {5'd0, disp_on, cursor_on, blink_on}, 8'h02);
    ins(8'h23);
    chk("R2 func", {4'd0, bus_8bit, two_line, bright}, 8'h03);
    ins(8'h3A);
    chk("R2 func", {4'd0, bus_8bit, two_line, bright}, 8'h0E);
    ins(8'h38);
    ins(8'h08);
    ins(8'h06);
  endtask

  task automatic t_two_line;
    ins(8'hA7); wrd(8'h11);
    chk("R3 27->40", {1'b0, ac_out}, 8'h40);
    ins(8'hE7); wrd(8'h11);
    chk("R3 67->00", {1'b0, ac_out}, 8'h00);
    ins(8'h04);
    ins(8'hC0); wrd(8'h11);
    chk("R3 40->27", {1'b0, ac_out}, 8'h27);
    ins(8'h80); wrd(8'h11);
    chk("R3 00->67", {1'b0, ac_out}, 8'h67);
    ins(8'h06);
  endtask

  task automatic t_one_line;
    ins(8'h30);
    ins(8'hCF); wrd(8'h22);
    chk("R4 4F->00", {1'b0, ac_out}, 8'h00);
    ins(8'h04); wrd(8'h22);
    chk("R4 00->4F", {1'b0, ac_out}, 8'h4F);
    ins(8'h06);
    ins(8'h7F); wrd(8'h22);
    chk("R4 g3F->00", {ac_is_glyph, ac_out}, 8'h80);
    ins(8'h04); wrd(8'h22);
    chk("R4 g00->3F", {ac_is_glyph, ac_out}, 8'hBF);
    ins(8'h06);
    ins(8'h38);
  endtask

  task automatic t_data;
    ins(8'h90); wrd(8'h41); wrd(8'h42);
    ins(8'h90);
    rdd("R5 char rd0", 8'h41);
    rdd("R5 char rd1", 8'h42);
    chk("R5 ac step", {1'b0, ac_out}, 8'h12);
    ins(8'h48); wrd(8'h15);
    ins(8'h88);
    rdd("R5 char sel", 8'h20);
    ins(8'h48);
    rdd("R5 glyph sel", 8'h15);
  endtask

  task automatic t_shift;
    ins(8'h02);
    ins(8'h07); wrd(8'h61);
    chk("R6 left", {1'b0, shift_offset}, 8'h01);
    ins(8'h05); wrd(8'h61);
    chk("R6 right", {1'b0, shift_offset}, 8'h00);
    wrd(8'h61);
    chk("R6 wrap 40", {1'b0, shift_offset}, 8'd39);
    send(1'b1, 1'b1, 8'h00);
    chk("R6 read no shift", {1'b0, shift_offset}, 8'd39);
    ins(8'h40); wrd(8'h01);
    chk("R6 glyph no shift", {1'b0, shift_offset}, 8'd39);
    ins(8'h06);
    ins(8'h02);
  endtask

  task automatic t_cursor;
    ins(8'h02);
    ins(8'h14);
    chk("R7 inc", {1'b0, ac_out}, 8'h01);
    ins(8'h10);
    chk("R7 dec", {1'b0, ac_out}, 8'h00);
    ins(8'h10);
    chk("R7 dec wrap", {1'b0, ac_out}, 8'h67);
    chk("R7 no disp", {1'b0, shift_offset}, 8'h00);
    ins(8'h1C);
    chk("R7 sc inc ac", {1'b0, ac_out}, 8'h00);
    chk("R7 sc right", {1'b0, shift_offset}, 8'd39);
    ins(8'h18);
    chk("R7 sc dec ac", {1'b0, ac_out}, 8'h67);
    chk("R7 sc left", {1'b0, shift_offset}, 8'h00);
    ins(8'h45); ins(8'h14);
    chk("R7 to char", {ac_is_glyph, ac_out}, 8'h06);
  endtask

  task automatic t_acread;
    ins(8'hC5);
    send(1'b0, 1'b1, 8'h00);
    chk("R8 rd_valid", {7'd0, rd_valid}, 8'h01);
    chk("R8 bf+ac", rd_data, 8'h45);
  endtask

  task automatic t_clear;
    ins(8'h40); wrd(8'h1F);
    ins(8'h04); ins(8'h18);
    chk("R9 pre off", {1'b0, shift_offset}, 8'h01);
    ins(8'h01);
    chk("R9 ac", {ac_is_glyph, ac_out}, 8'h00);
    chk("R9 off", {1'b0, shift_offset}, 8'h00);
    chk("R9 inc", {7'd0, inc_mode}, 8'h01);
    idle(140);
    ins(8'h90);
    rdd("R9 filled", 8'h20);
    ins(8'h40);
    rdd("R9 glyph kept", 8'h1F);
  endtask

  task automatic t_home;
    ins(8'hB0); wrd(8'h5A);
    ins(8'h1C);
    ins(8'h02);
    chk("R10 ac", {ac_is_glyph, ac_out}, 8'h00);
    chk("R10 off", {1'b0, shift_offset}, 8'h00);
    ins(8'hB0);
    rdd("R10 ram kept", 8'h5A);
  endtask

  task automatic t_park;
    ins(8'h01);
    wrd(8'h51);
    idle(40);
    chk("R11 waiting", {1'b0, ac_out}, 8'h00);
    idle(120);
    chk("R11 ran", {1'b0, ac_out}, 8'h01);
    ins(8'h80);
    rdd("R11 data kept", 8'h51);
    rdd("R11 fill done", 8'h20);
  endtask

  task automatic t_blink;
    ins(8'h0D);
    chk("R12 on", {7'd0, blink_on}, 8'h01);
    idle(HALF - 1);
    chk("R12 before", {7'd0, blink_phase}, 8'h00);
    idle(1);
    chk("R12 toggle", {7'd0, blink_phase}, 8'h01);
    idle(HALF);
    chk("R12 toggle back", {7'd0, blink_phase}, 8'h00);
    idle(HALF);
    chk("R12 high again", {7'd0, blink_phase}, 8'h01);
    ins(8'h0C);
    idle(1);
    chk("R12 off", {7'd0, blink_phase}, 8'h00);
    idle(HALF + 2);
    chk("R12 held", {7'd0, blink_phase}, 8'h00);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_decode;
    t_two_line;
    t_one_line;
    t_data;
    t_shift;
    t_cursor;
    t_acread;
    t_clear;
    t_home;
    t_park;
    t_blink;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule